// File: doc/BRIEF.md
# Radix-4 Add-Compare-Select Array

This block is the metric update core of a 32-state Viterbi decoder for a rate-1/2 convolutional code with constraint length 6. Each accepted step folds two radix-2 trellis stages into one: every state takes four predecessor metrics from two stages back. It adds to each the branch metric of the two-stage transition that joins them and keeps the smallest sum. It also reports which of the four predecessors won, as a 2-bit decision per state. A survivor memory further down the chain consumes these decisions.

The sixteen radix-4 branch metrics arrive on one bus, one per possible group of four coded bits, with a strobe. The state metrics are 8 bits wide. They are allowed to wrap past 255 without saturation or rescaling. All comparisons use the sign of the modular difference, which is safe because the trellis bounds the spread between live metrics well below half the 256 range. On reset the metrics load a fixed table that favours the all-zero start state.

Top module: `r4AcsArray`

## Requirements
- R1: While reset (`rstN` low, sampled at a rising edge) is applied, the next state loads state metric 0 with 0 and every other state metric with 28. All decisions become 0 and `outValid` becomes 0.
- R2: On a rising edge with `inValid` high, the new metric of state s becomes the smallest of four candidates, one for each j in 0..3. Candidate j is metric[p] + branch metric, where p = ((s << 2) | j) mod 32. The branch metric is the 5-bit field at bit offset 5·label of `branchMetrics`.
- R3: The label of transition (p → s) is the 4-bit value {c1a, c1b, c2a, c2b}, with c1a as the MSB. Here r1 = {s[3], p} and r2 = {s[4], s[3], p[4:1]} are 6-bit encoder registers, newest bit at bit 5. Each c?a is the XOR of the bits of r & 6'b110101, and each c?b is the XOR of the bits of r & 6'b101111 (r1 for c1, r2 for c2).
- R4: The decision of state s, bits [2s+1:2s] of `decisions`, is the index j of the winning candidate. Its metric equals the new state metric.
- R5: When candidates tie for the minimum, the lowest j wins.
- R6: Sums are taken modulo 256 with no saturation. Candidate a counts as smaller than b exactly when bit 7 of (a − b) mod 256 is set, so the ordering stays correct after metrics wrap past 255.
- R7: On a rising edge with `inValid` low, the state metrics and decisions keep their values whatever `branchMetrics` carries.
- R8: `outValid` is high in the cycle after a rising edge that accepted `inValid` high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low; loads the start table |
| inValid | input | 1 | Branch metrics on this edge are to be used for one radix-4 step |
| branchMetrics | input | 80 | Sixteen 5-bit radix-4 branch metrics, label L at bits [5L+4:5L] |
| stateMetrics | output | 256 | Thirty-two 8-bit state metrics, state s at bits [8s+7:8s] |
| decisions | output | 64 | Thirty-two 2-bit winning-predecessor indices, state s at bits [2s+1:2s] |
| outValid | output | 1 | Metrics and decisions were updated on the previous edge |

## Verification
On every cycle the assertions check four things. They check the reset table and the hold of metrics and decisions on idle edges. They check that `outValid` follows the accepted strobe. For each updated state, they check that no candidate lies below the new metric in the modular order and that the reported decision points at a candidate equal to it. The bench scenarios alone can show that the trellis wiring and branch labels match the encoder, and that ties go to the lowest predecessor rather than just any minimal one. They also show that a long run of large branch metrics carries every metric through the 255-to-0 wrap without the ordering breaking.

// File: rtl/r4AcsPkg.sv
package r4AcsPkg;

  // Predecessors per state in one two-stage step and width of their index.
  localparam int RADIX = 4;
  localparam int SEL_W = 2;
  // Four coded bits per radix-4 step give sixteen distinct branch labels.
  localparam int LABELS = 16;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic loadInit;
    logic update;
  } acsStrobes_t;

  function automatic int parity32(int v);
    int acc;
    acc = 0;
    for (int b = 0; b < 32; b++) acc = acc ^ ((v >> b) & 1);
    return acc;
  endfunction

  // Label of the two-stage transition from predecessor index j into state s.
  // The newest input bit sits at the top of the encoder register.
  function automatic int branchLabel(int s, int j, int stW, int nStates,
                                     int genA, int genB);
    int p;
    int u1;
    int u2;
    int r1;
    int r2;
    p  = (s * RADIX + j) % nStates;
    u1 = (s >> (stW - 2)) & 1;
    u2 = (s >> (stW - 1)) & 1;
    r1 = (u1 << stW) | p;
    r2 = (u2 << stW) | (u1 << (stW - 1)) | (p >> 1);
    return (parity32(r1 & genA) << 3) | (parity32(r1 & genB) << 2) |
           (parity32(r2 & genA) << 1) | parity32(r2 & genB);
  endfunction

endpackage

// File: rtl/r4ModPick.sv
module r4ModPick #(
  parameter int MET_W = 8
) (
  input  logic [MET_W-1:0] aMetric,
  input  logic [MET_W-1:0] bMetric,
  output logic             takeB,
  output logic [MET_W-1:0] winMetric
);

  // b wins only when strictly below a in the modular order: sign bit of b - a.
  logic [MET_W-1:0] modDiff;

  always_comb begin
    modDiff   = bMetric - aMetric;
    takeB     = modDiff[MET_W-1];
    winMetric = takeB ? bMetric : aMetric;
  end

endmodule

// File: rtl/r4AcsNode.sv
module r4AcsNode #(
  parameter int MET_W = 8,
  parameter int BM_W  = 5
) (
  input  logic [MET_W-1:0]             predMetric   [r4AcsPkg::RADIX],
  input  logic [BM_W-1:0]              branchMetric [r4AcsPkg::RADIX],
  output logic [MET_W-1:0]             newMetric,
  output logic [r4AcsPkg::SEL_W-1:0]   winner
);

  localparam int PAD_W = MET_W - BM_W;

  logic [MET_W-1:0] cand [r4AcsPkg::RADIX];

  // Add stage: wrapping sums, the overflow bit is simply dropped.
  for (genvar j = 0; j < r4AcsPkg::RADIX; j++) begin : gAdd
    assign cand[j] = predMetric[j] + {{PAD_W{1'b0}}, branchMetric[j]};
  end

  // Compare-select tournament: (0,1) and (2,3) first, then the two winners.
  logic             loTakeB;
  logic             hiTakeB;
  logic             finTakeB;
  logic [MET_W-1:0] loWin;
  logic [MET_W-1:0] hiWin;

  r4ModPick #(.MET_W(MET_W)) pickLo (
    .aMetric  (cand[0]),
    .bMetric  (cand[1]),
    .takeB    (loTakeB),
    .winMetric(loWin)
  );

  r4ModPick #(.MET_W(MET_W)) pickHi (
    .aMetric  (cand[2]),
    .bMetric  (cand[3]),
    .takeB    (hiTakeB),
    .winMetric(hiWin)
  );

  r4ModPick #(.MET_W(MET_W)) pickFin (
    .aMetric  (loWin),
    .bMetric  (hiWin),
    .takeB    (finTakeB),
    .winMetric(newMetric)
  );

  always_comb begin
    winner = finTakeB ? {1'b1, hiTakeB} : {1'b0, loTakeB};
  end

endmodule

// File: rtl/r4AcsCtrl.sv
module r4AcsCtrl (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  output r4AcsPkg::acsStrobes_t  strobes,
  output logic                   outValid
);

  always_comb begin
    strobes.loadInit = !rstN;
    strobes.update   = rstN && inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/r4AcsPath.sv
module r4AcsPath #(
  parameter int NUM_STATES    = 32,
  parameter int MET_W         = 8,
  parameter int BM_W          = 5,
  parameter int START_PENALTY = 28,
  parameter int GEN_A         = 53,
  parameter int GEN_B         = 47
) (
  input  logic                                      clk,
  input  r4AcsPkg::acsStrobes_t                     strobes,
  input  logic [r4AcsPkg::LABELS*BM_W-1:0]          bmFlat,
  output logic [NUM_STATES*MET_W-1:0]               metricsFlat,
  output logic [NUM_STATES*r4AcsPkg::SEL_W-1:0]     decisionsFlat
);

  localparam int ST_W  = $clog2(NUM_STATES);
  localparam int RADIX = r4AcsPkg::RADIX;
  localparam int SEL_W = r4AcsPkg::SEL_W;

  logic [MET_W-1:0] metricReg  [NUM_STATES];
  logic [MET_W-1:0] metricNext [NUM_STATES];
  logic [SEL_W-1:0] decReg     [NUM_STATES];
  logic [SEL_W-1:0] decNext    [NUM_STATES];

  for (genvar s = 0; s < NUM_STATES; s++) begin : gState
    logic [MET_W-1:0] predM [RADIX];
    logic [BM_W-1:0]  brM   [RADIX];

    // Fixed trellis wiring: predecessor index and branch label per input.
    for (genvar j = 0; j < RADIX; j++) begin : gIn
      localparam int PRED = (s * RADIX + j) % NUM_STATES;
      localparam int LBL  = r4AcsPkg::branchLabel(s, j, ST_W, NUM_STATES,
                                                  GEN_A, GEN_B);
      assign predM[j] = metricReg[PRED];
      assign brM[j]   = bmFlat[LBL*BM_W +: BM_W];
    end

    r4AcsNode #(.MET_W(MET_W), .BM_W(BM_W)) node (
      .predMetric  (predM),
      .branchMetric(brM),
      .newMetric   (metricNext[s]),
      .winner      (decNext[s])
    );

    // Start table: the encoder is known to begin in state 0.
    localparam logic [MET_W-1:0] INIT_MET =
      (s == 0) ? '0 : MET_W'(START_PENALTY);

    always_ff @(posedge clk) begin
      if (strobes.loadInit) begin
        metricReg[s] <= INIT_MET;
        decReg[s]    <= '0;
      end else if (strobes.update) begin
        metricReg[s] <= metricNext[s];
        decReg[s]    <= decNext[s];
      end
    end

    assign metricsFlat[s*MET_W +: MET_W]   = metricReg[s];
    assign decisionsFlat[s*SEL_W +: SEL_W] = decReg[s];
  end

endmodule

// File: rtl/r4AcsArray.sv
module r4AcsArray #(
  parameter int NUM_STATES    = 32,
  parameter int MET_W         = 8,
  parameter int BM_W          = 5,
  parameter int START_PENALTY = 28,
  parameter int GEN_A         = 53,
  parameter int GEN_B         = 47
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  inValid,
  input  logic [r4AcsPkg::LABELS*BM_W-1:0]      branchMetrics,
  output logic [NUM_STATES*MET_W-1:0]           stateMetrics,
  output logic [NUM_STATES*r4AcsPkg::SEL_W-1:0] decisions,
  output logic                                  outValid
);

  r4AcsPkg::acsStrobes_t strobes;

  r4AcsCtrl ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  r4AcsPath #(
    .NUM_STATES   (NUM_STATES),
    .MET_W        (MET_W),
    .BM_W         (BM_W),
    .START_PENALTY(START_PENALTY),
    .GEN_A        (GEN_A),
    .GEN_B        (GEN_B)
  ) path (
    .clk          (clk),
    .strobes      (strobes),
    .bmFlat       (branchMetrics),
    .metricsFlat  (stateMetrics),
    .decisionsFlat(decisions)
  );

endmodule

// File: rtl/r4AcsArrayChk.sv
module r4AcsArrayChk #(
  parameter int NUM_STATES    = 32,
  parameter int MET_W         = 8,
  parameter int BM_W          = 5,
  parameter int START_PENALTY = 28,
  parameter int GEN_A         = 53,
  parameter int GEN_B         = 47
) (
  input logic                                  clk,
  input logic                                  rstN,
  input logic                                  inValid,
  input logic [r4AcsPkg::LABELS*BM_W-1:0]      bmFlat,
  input logic [NUM_STATES*MET_W-1:0]           metricsFlat,
  input logic [NUM_STATES*r4AcsPkg::SEL_W-1:0] decisionsFlat,
  input logic                                  outValid
);

  localparam int ST_W  = $clog2(NUM_STATES);
  localparam int RADIX = r4AcsPkg::RADIX;
  localparam int SEL_W = r4AcsPkg::SEL_W;

  logic [NUM_STATES*MET_W-1:0]      prevMetrics;
  logic [r4AcsPkg::LABELS*BM_W-1:0] prevBm;
  logic [NUM_STATES*MET_W-1:0]      initFlat;

  always_ff @(posedge clk) begin
    prevMetrics <= metricsFlat;
    prevBm      <= bmFlat;
  end

  always_comb begin
    initFlat = '0;
    for (int s = 1; s < NUM_STATES; s++)
      initFlat[s*MET_W +: MET_W] = MET_W'(START_PENALTY);
  end

  // R1
  reset_table_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (metricsFlat == initFlat) && (decisionsFlat == '0) && !outValid);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(inValid)) |-> $stable(metricsFlat) && $stable(decisionsFlat));

  // R8
  out_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (outValid == $past(inValid)));

  for (genvar s = 0; s < NUM_STATES; s++) begin : gChk
    logic [MET_W-1:0] cand    [RADIX];
    logic [MET_W-1:0] gap     [RADIX];
    logic [MET_W-1:0] newM;
    logic [SEL_W-1:0] dec;

    assign newM = metricsFlat[s*MET_W +: MET_W];
    assign dec  = decisionsFlat[s*SEL_W +: SEL_W];

    for (genvar j = 0; j < RADIX; j++) begin : gCand
      localparam int PRED = (s * RADIX + j) % NUM_STATES;
      localparam int LBL  = r4AcsPkg::branchLabel(s, j, ST_W, NUM_STATES,
                                                  GEN_A, GEN_B);
      assign cand[j] = prevMetrics[PRED*MET_W +: MET_W] +
                       MET_W'(prevBm[LBL*BM_W +: BM_W]);
      assign gap[j]  = cand[j] - newM;

      // R2 R6
      no_smaller_cand_chk: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && outValid) |-> !gap[j][MET_W-1]);
    end

    // R4
    decision_match_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && outValid) |-> (cand[dec] == newM));
  end

endmodule

bind r4AcsArray r4AcsArrayChk #(
  .NUM_STATES   (NUM_STATES),
  .MET_W        (MET_W),
  .BM_W         (BM_W),
  .START_PENALTY(START_PENALTY),
  .GEN_A        (GEN_A),
  .GEN_B        (GEN_B)
) chkInst (
  .clk          (clk),
  .rstN         (rstN),
  .inValid      (inValid),
  .bmFlat       (branchMetrics),
  .metricsFlat  (stateMetrics),
  .decisionsFlat(decisions),
  .outValid     (outValid)
);

// File: tb/r4AcsArray_test.sv
module r4AcsArray_test;

  localparam int NS = 32;
  localparam int MW = 8;
  localparam int BW = 5;
  localparam int NL = 16;
  localparam logic [5:0] POLY_A = 6'b110101;
  localparam logic [5:0] POLY_B = 6'b101111;

  // Stimulus table: each seed expands into sixteen branch metrics in 0..28.
  localparam int NVEC = 6;
  localparam int SEEDS [NVEC] = '{3, 11, 0, 17, 25, 7};

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic [NL*BW-1:0]  branchMetrics = '0;
  logic [NS*MW-1:0]  stateMetrics;
  logic [NS*2-1:0]   decisions;
  logic              outValid;

  int expM [NS];
  int expD [NS];
  int nChecks = 0;
  int nFails = 0;
  bit summaryDone = 0;

  always #10 clk = ~clk;

  r4AcsArray uut (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .branchMetrics(branchMetrics),
    .stateMetrics (stateMetrics),
    .decisions    (decisions),
    .outValid     (outValid)
  );

  // R3: label of transition p -> s from the two encoder registers.
  function automatic logic [3:0] labelOf(int s, int j);
    logic [4:0] sv;
    logic [4:0] p;
    logic [5:0] r1;
    logic [5:0] r2;
    sv = 5'(s);
    p  = {sv[2:0], 2'(j)};
    r1 = {sv[3], p};
    r2 = {sv[4], sv[3], p[4:1]};
    return {^(r1 & POLY_A), ^(r1 & POLY_B), ^(r2 & POLY_A), ^(r2 & POLY_B)};
  endfunction

  // R6: signed view of the 8-bit modular difference.
  function automatic bit below(int a, int b);
    logic signed [7:0] d;
    d = 8'(a - b);
    return d < 0;
  endfunction

  function automatic logic [NL*BW-1:0] bmFromSeed(int seed);
    logic [NL*BW-1:0] v;
    for (int l = 0; l < NL; l++) v[l*BW +: BW] = 5'((seed * (l + 3) + l * l) % 29);
    return v;
  endfunction

  task automatic modelReset();
    for (int s = 0; s < NS; s++) begin
      expM[s] = (s == 0) ? 0 : 28;
      expD[s] = 0;
    end
  endtask

  task automatic modelStep(logic [NL*BW-1:0] bm);
    int nm [NS];
    int nd [NS];
    for (int s = 0; s < NS; s++) begin
      int c [4];
      int best;
      for (int j = 0; j < 4; j++) begin
        int p;
        p = (s * 4 + j) % NS;
        c[j] = (expM[p] + int'(bm[labelOf(s, j)*BW +: BW])) % 256;
      end
      best = 0;
      for (int j = 1; j < 4; j++) if (below(c[j], c[best])) best = j;
      nm[s] = c[best];
      nd[s] = best;
    end
    for (int s = 0; s < NS; s++) begin
      expM[s] = nm[s];
      expD[s] = nd[s];
    end
  endtask

  task automatic check(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compareState(string req);
    logic [NS*MW-1:0] em;
    logic [NS*2-1:0]  ed;
    for (int s = 0; s < NS; s++) begin
      em[s*MW +: MW] = 8'(expM[s]);
      ed[s*2 +: 2]   = 2'(expD[s]);
    end
    check(stateMetrics == em, req, "state metrics", stateMetrics, em);
    check(decisions == ed, req, "decisions", 256'(decisions), 256'(ed));
  endtask

  // One accepted step; outputs are sampled at the falling edge after it.
  task automatic applyStep(logic [NL*BW-1:0] bm, string req);
    @(negedge clk);
    branchMetrics = bm;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    modelStep(bm);
    check(outValid == 1'b1, "R8", "outValid after step", 256'(outValid), 256'(1));
    compareState(req);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  task automatic finish();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    doReset();
    @(negedge clk);
    // R1: start table, zero decisions, no output strobe.
    compareState("R1");
    check(outValid == 1'b0, "R1", "outValid after reset", 256'(outValid), 256'(0));

    // R2 R3 R4: table walk through the stimulus vectors.
    for (int v = 0; v < NVEC; v++) applyStep(bmFromSeed(SEEDS[v]), "R2");

    // R8: strobe drops one cycle after an idle edge.
    @(negedge clk);
    check(outValid == 1'b0, "R8", "outValid idle", 256'(outValid), 256'(0));

    // R7: new branch metrics without the strobe leave state untouched.
    branchMetrics = bmFromSeed(19);
    repeat (3) @(negedge clk);
    compareState("R7");
    check(outValid == 1'b0, "R7", "outValid while idle", 256'(outValid), 256'(0));

    // R5: equal candidates everywhere pick predecessor 0.
    doReset();
    applyStep('0, "R5");
    check(decisions == '0, "R5", "tie decisions", 256'(decisions), 256'(0));

    // R5: ties where the lowest index differs from 0 for some states.
    begin
      logic [NL*BW-1:0] bm;
      for (int l = 0; l < NL; l++) bm[l*BW +: BW] = 5'((l % 4) * 7);
      applyStep(bm, "R5");
      applyStep(bm, "R5");
    end

    // R6: large metrics drive every state through the 255 to 0 wrap.
    for (int k = 0; k < 20; k++) begin
      logic [NL*BW-1:0] bm;
      for (int l = 0; l < NL; l++) bm[l*BW +: BW] = 5'(20 + (l * 3 + k) % 9);
      applyStep(bm, "R6");
    end

    // R1: a second reset restores the start table mid-stream.
    doReset();
    @(negedge clk);
    compareState("R1");

    finish();
  end

endmodule